// File: doc/BRIEF.md
# Aliased Header Field Read Unit

This block reads one IPv4 or IPv6 header field in a single access. Each field has its own alias address. The alias indexes an offset table, which returns the index of the 32-bit word that holds the field. The unit adds that index to the header base address of the selected protocol. The sum is the physical word address, and the word at that address is read combinationally from a local register-array memory. A decoder then enables exactly one field extractor. That extractor shifts the field down to bit 0 and clears every bit above it. The result appears in the same cycle the alias is applied.

The two header base addresses live in a small register pair with its own write port. This lets software or a packet-handling engine move the header window in memory. The memory model has a synchronous write port, so header words can be placed before they are read. Fields are packed most significant bit first within each word. IPv6 fields after the second header word are not covered.

Top module: `hdr_field_reader`

## Requirements
- R1: After reset, the IPv4 base is 0x0808 and the IPv6 base is 0x0C00. This is seen on `word_addr` for alias 0x00 (0x0808) and alias 0x0D (0x0C00).
- R2: For a valid alias, `word_addr` equals the protocol base plus the word index. IPv4 uses aliases 0x00–0x0C: 0x00–0x04 map to word 0, 0x05–0x08 to word 1, and 0x09–0x0C to word 2. IPv6 uses aliases 0x0D–0x12: 0x0D–0x0F map to word 0 and 0x10–0x12 to word 1.
- R3: The IPv4 fields, given as alias: bit slice of the addressed word, are:
  - word 0: 0x00 [31:28], 0x01 [27:24], 0x02 [23:16], 0x03 [31:16], 0x04 [15:0]
  - word 1: 0x05 [31:16], 0x06 [15:13], 0x07 [12:0], 0x08 [15:0]
  - word 2: 0x09 [31:24], 0x0A [23:16], 0x0B [31:16], 0x0C [15:0]

  Each field is returned on `field_data` right-aligned, with all higher bits zero.
- R4: The IPv6 fields, given as alias: bit slice of the addressed word, are:
  - word 0: 0x0D [31:28], 0x0E [27:20], 0x0F [19:0]
  - word 1: 0x10 [31:16], 0x11 [15:8], 0x12 [7:0]

  Each field is returned right-aligned and zero-extended.
- R5: An alias above 0x12 drives `addr_invalid` to 1, `field_data` to 0 and `word_addr` to 0. A valid alias drives `addr_invalid` to 0.
- R6: When `base_we` is 1 at a clock edge, `base_wdata` is loaded into the IPv4 base (`base_sel`=0) or the IPv6 base (`base_sel`=1). A read in that same cycle still uses the old base.
- R7: When `mem_we` is 1 at a clock edge, `mem_wdata` is stored at word `mem_waddr`. A read in the same cycle returns the old word, and reads are combinational from the next cycle on.
- R8: For a valid alias exactly one field extractor is enabled. For an invalid alias none is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_we | input | 1 | Base register write enable |
| base_sel | input | 1 | 0 selects the IPv4 base, 1 selects the IPv6 base |
| base_wdata | input | 16 | New base word address |
| mem_we | input | 1 | Memory write enable |
| mem_waddr | input | 12 | Memory write word address |
| mem_wdata | input | 32 | Memory write data |
| alias_addr | input | 8 | Field alias address |
| field_data | output | 32 | Extracted field, right-aligned and zero-extended |
| word_addr | output | 16 | Physical word address used for the read |
| addr_invalid | output | 1 | Alias is outside 0x00–0x12 |

## Verification
Two pairs of activities can fall in the same cycle. A base register load can coincide with a read through that base. A memory write can coincide with a read of the same word. The bench provokes each pair by driving the write and the alias in one cycle. It judges the result just before the edge, where the old base or old word is expected. It judges again just after the edge, where the new one must appear. Random alias reads, interleaved with random header rewrites and base relocations, also place writes next to reads of the words they touch.

// File: rtl/hfr_pkg.sv
package hfr_pkg;

    localparam int HFR_NUM_FIELDS = 19;
    localparam int HFR_V6_FIRST   = 13;
    localparam int HFR_OFF_W      = 2;

    // Bit position of the least significant bit of each field in its word
    function automatic int hfr_field_lsb(input int idx);
        case (idx)
            0:  return 28;
            1:  return 24;
            2:  return 16;
            3:  return 16;
            4:  return 0;
            5:  return 16;
            6:  return 13;
            7:  return 0;
            8:  return 0;
            9:  return 24;
            10: return 16;
            11: return 16;
            12: return 0;
            13: return 28;
            14: return 20;
            15: return 0;
            16: return 16;
            17: return 8;
            default: return 0;
        endcase
    endfunction

    // Field width in bits
    function automatic int hfr_field_width(input int idx);
        case (idx)
            0, 1, 13:                 return 4;
            2, 9, 10, 14, 17, 18:     return 8;
            6:                        return 3;
            7:                        return 13;
            15:                       return 20;
            default:                  return 16;
        endcase
    endfunction

    // Index of the header word that holds the field
    function automatic int hfr_field_word(input int idx);
        if (idx <= 4)                    return 0;
        else if (idx <= 8)               return 1;
        else if (idx < HFR_V6_FIRST)     return 2;
        else if (idx <= 15)              return 0;
        else                             return 1;
    endfunction

endpackage

// File: rtl/hfr_base_regs.sv
module hfr_base_regs #(
    parameter int ADDR_W = 16,
    parameter logic [ADDR_W-1:0] V4_RST = 16'h0808,
    parameter logic [ADDR_W-1:0] V6_RST = 16'h0C00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              base_we,
    input  logic              base_sel,
    input  logic [ADDR_W-1:0] base_wdata,
    output logic [ADDR_W-1:0] base_v4,
    output logic [ADDR_W-1:0] base_v6
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_v4 <= V4_RST;
            base_v6 <= V6_RST;
        end else if (base_we) begin
            if (base_sel) base_v6 <= base_wdata;
            else          base_v4 <= base_wdata;
        end
    end

endmodule

// File: rtl/hfr_offset_table.sv
module hfr_offset_table
    import hfr_pkg::*;
#(
    parameter int ALIAS_W = 8
) (
    input  logic [ALIAS_W-1:0]   alias_addr,
    output logic [HFR_OFF_W-1:0] word_off,
    output logic                 use_v6,
    output logic                 valid
);

    always_comb begin
        word_off = '0;
        use_v6   = 1'b0;
        valid    = (int'(alias_addr) < HFR_NUM_FIELDS);
        for (int i = 0; i < HFR_NUM_FIELDS; i++) begin
            if (int'(alias_addr) == i) begin
                word_off = HFR_OFF_W'(hfr_field_word(i));
                use_v6   = (i >= HFR_V6_FIRST);
            end
        end
    end

endmodule

// File: rtl/hfr_field_decoder.sv
module hfr_field_decoder
    import hfr_pkg::*;
#(
    parameter int ALIAS_W = 8
) (
    input  logic [ALIAS_W-1:0]        alias_addr,
    output logic [HFR_NUM_FIELDS-1:0] field_en
);

    always_comb begin
        for (int i = 0; i < HFR_NUM_FIELDS; i++) begin
            field_en[i] = (int'(alias_addr) == i);
        end
    end

endmodule

// File: rtl/hfr_field_unit.sv
module hfr_field_unit #(
    parameter int DATA_W = 32,
    parameter int LSB    = 0,
    parameter int WIDTH  = 8
) (
    input  logic              en,
    input  logic [DATA_W-1:0] word,
    output logic [DATA_W-1:0] field
);

    localparam logic [DATA_W-1:0] MASK = {{(DATA_W-WIDTH){1'b0}}, {WIDTH{1'b1}}};

    logic [DATA_W-1:0] shifted;

    always_comb begin
        shifted = word >> LSB;
        field   = en ? (shifted & MASK) : '0;
    end

endmodule

// File: rtl/hfr_header_mem.sv
module hfr_header_mem #(
    parameter int DATA_W = 32,
    parameter int MEM_AW = 12
) (
    input  logic              clk,
    input  logic              we,
    input  logic [MEM_AW-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [MEM_AW-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);

    localparam int DEPTH = 1 << MEM_AW;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/hdr_field_reader.sv
module hdr_field_reader
    import hfr_pkg::*;
#(
    parameter int ALIAS_W = 8,
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 32,
    parameter int MEM_AW  = 12,
    parameter logic [ADDR_W-1:0] V4_BASE_RST = 16'h0808,
    parameter logic [ADDR_W-1:0] V6_BASE_RST = 16'h0C00
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               base_we,
    input  logic               base_sel,
    input  logic [ADDR_W-1:0]  base_wdata,
    input  logic               mem_we,
    input  logic [MEM_AW-1:0]  mem_waddr,
    input  logic [DATA_W-1:0]  mem_wdata,
    input  logic [ALIAS_W-1:0] alias_addr,
    output logic [DATA_W-1:0]  field_data,
    output logic [ADDR_W-1:0]  word_addr,
    output logic               addr_invalid
);

    logic [ADDR_W-1:0]         base_v4;
    logic [ADDR_W-1:0]         base_v6;
    logic [HFR_OFF_W-1:0]      word_off;
    logic                      use_v6;
    logic                      alias_ok;
    logic [HFR_NUM_FIELDS-1:0] field_en;
    logic [DATA_W-1:0]         rd_word;
    logic [DATA_W-1:0]         unit_out [HFR_NUM_FIELDS];

    hfr_base_regs #(
        .ADDR_W (ADDR_W),
        .V4_RST (V4_BASE_RST),
        .V6_RST (V6_BASE_RST)
    ) u_base (
        .clk        (clk),
        .rst_n      (rst_n),
        .base_we    (base_we),
        .base_sel   (base_sel),
        .base_wdata (base_wdata),
        .base_v4    (base_v4),
        .base_v6    (base_v6)
    );

    hfr_offset_table #(.ALIAS_W(ALIAS_W)) u_table (
        .alias_addr (alias_addr),
        .word_off   (word_off),
        .use_v6     (use_v6),
        .valid      (alias_ok)
    );

    hfr_field_decoder #(.ALIAS_W(ALIAS_W)) u_dec (
        .alias_addr (alias_addr),
        .field_en   (field_en)
    );

    always_comb begin
        if (alias_ok) word_addr = (use_v6 ? base_v6 : base_v4) + ADDR_W'(word_off);
        else          word_addr = '0;
    end

    assign addr_invalid = !alias_ok;

    hfr_header_mem #(.DATA_W(DATA_W), .MEM_AW(MEM_AW)) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .raddr (word_addr[MEM_AW-1:0]),
        .rdata (rd_word)
    );

    for (genvar g = 0; g < HFR_NUM_FIELDS; g++) begin : g_unit
        hfr_field_unit #(
            .DATA_W (DATA_W),
            .LSB    (hfr_field_lsb(g)),
            .WIDTH  (hfr_field_width(g))
        ) u_fl (
            .en    (field_en[g]),
            .word  (rd_word),
            .field (unit_out[g])
        );
    end

    always_comb begin
        field_data = '0;
        for (int i = 0; i < HFR_NUM_FIELDS; i++) begin
            field_data = field_data | unit_out[i];
        end
    end

endmodule

// File: rtl/hfr_checker.sv
module hfr_checker
    import hfr_pkg::*;
#(
    parameter int ALIAS_W = 8,
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 32
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [ALIAS_W-1:0]        alias_addr,
    input logic [DATA_W-1:0]         field_data,
    input logic [ADDR_W-1:0]         word_addr,
    input logic                      addr_invalid,
    input logic [HFR_NUM_FIELDS-1:0] field_en,
    input logic [ADDR_W-1:0]         base_v4,
    input logic [ADDR_W-1:0]         base_v6,
    input logic                      base_we,
    input logic                      base_sel,
    input logic [ADDR_W-1:0]         base_wdata
);

    assert_base_v4_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (base_we && !base_sel) |=> base_v4 == $past(base_wdata));

    assert_base_v6_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (base_we && base_sel) |=> base_v6 == $past(base_wdata));

    assert_invalid_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        addr_invalid |-> (field_data == '0 && word_addr == '0));

    assert_one_unit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_invalid |-> $countones(field_en) == 1);

    assert_no_unit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        addr_invalid |-> field_en == '0);

    assert_v4_word0_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (alias_addr == 8'h00) |-> word_addr == base_v4);

    assert_v6_word1_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (alias_addr == 8'h12) |-> word_addr == base_v6 + 16'd1);

    assert_v4_nibble_zext_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (alias_addr == 8'h00) |-> field_data[DATA_W-1:4] == '0);

    assert_v6_flow_zext_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (alias_addr == 8'h0F) |-> field_data[DATA_W-1:20] == '0);

endmodule

bind hdr_field_reader hfr_checker #(
    .ALIAS_W (ALIAS_W),
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .alias_addr   (alias_addr),
    .field_data   (field_data),
    .word_addr    (word_addr),
    .addr_invalid (addr_invalid),
    .field_en     (field_en),
    .base_v4      (base_v4),
    .base_v6      (base_v6),
    .base_we      (base_we),
    .base_sel     (base_sel),
    .base_wdata   (base_wdata)
);

// File: tb/hdr_field_reader_test.sv
`timescale 1ns/1ps
module hdr_field_reader_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        base_we = 1'b0;
    logic        base_sel = 1'b0;
    logic [15:0] base_wdata = '0;
    logic        mem_we = 1'b0;
    logic [11:0] mem_waddr = '0;
    logic [31:0] mem_wdata = '0;
    logic [7:0]  alias_addr = '0;
    logic [31:0] field_data;
    logic [15:0] word_addr;
    logic        addr_invalid;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] model_mem [4096];
    logic [15:0] m_b4 = 16'h0808;
    logic [15:0] m_b6 = 16'h0C00;

    always #2 clk = ~clk;

    hdr_field_reader uut (
        .clk(clk), .rst_n(rst_n), .base_we(base_we), .base_sel(base_sel),
        .base_wdata(base_wdata), .mem_we(mem_we), .mem_waddr(mem_waddr),
        .mem_wdata(mem_wdata), .alias_addr(alias_addr), .field_data(field_data),
        .word_addr(word_addr), .addr_invalid(addr_invalid)
    );

    function automatic int exp_word(input int a);
        if (a < 5) return 0;
        if (a < 9) return 1;
        if (a < 13) return 2;
        if (a < 16) return 0;
        return 1;
    endfunction

    function automatic logic [15:0] exp_addr(input int a);
        if (a > 18) return 16'h0;
        return (a < 13 ? m_b4 : m_b6) + 16'(exp_word(a));
    endfunction

    function automatic logic [31:0] exp_field(input int a, input logic [31:0] w);
        case (a)
            0, 13:      return {28'h0, w[31:28]};
            1:          return {28'h0, w[27:24]};
            2, 10:      return {24'h0, w[23:16]};
            3, 5, 11, 16: return {16'h0, w[31:16]};
            4, 8, 12:   return {16'h0, w[15:0]};
            6:          return {29'h0, w[15:13]};
            7:          return {19'h0, w[12:0]};
            9:          return {24'h0, w[31:24]};
            14:         return {24'h0, w[27:20]};
            15:         return {12'h0, w[19:0]};
            17:         return {24'h0, w[15:8]};
            18:         return {24'h0, w[7:0]};
            default:    return 32'h0;
        endcase
    endfunction

    function automatic string req_of(input int a);
        if (a < 13) return "R3";
        if (a < 19) return "R4";
        return "R5";
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic write_mem(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        mem_we = 1'b1; mem_waddr = a; mem_wdata = d;
        @(negedge clk);
        mem_we = 1'b0;
        model_mem[a] = d;
    endtask

    task automatic write_base(input logic sel, input logic [15:0] v);
        @(negedge clk);
        base_we = 1'b1; base_sel = sel; base_wdata = v;
        @(negedge clk);
        base_we = 1'b0;
        if (sel) m_b6 = v; else m_b4 = v;
    endtask

    task automatic read_check(input int a);
        logic [15:0] ea;
        @(negedge clk);
        alias_addr = 8'(a);
        #1;
        ea = exp_addr(a);
        chk("R2 word_addr", {16'h0, word_addr}, {16'h0, ea});
        chk("R5 addr_invalid", {31'h0, addr_invalid}, {31'h0, (a > 18)});
        chk({req_of(a), " field_data"}, field_data,
            (a > 18) ? 32'h0 : exp_field(a, model_mem[ea[11:0]]));
    endtask

    task automatic fill_header(input logic v6);
        if (v6) begin
            for (int k = 0; k < 2; k++) write_mem(m_b6[11:0] + 12'(k), $urandom);
        end else begin
            for (int k = 0; k < 3; k++) write_mem(m_b4[11:0] + 12'(k), $urandom);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset bases seen through word_addr
        @(negedge clk); alias_addr = 8'h00; #1;
        chk("R1 ipv4 base", {16'h0, word_addr}, 32'h0808);
        @(negedge clk); alias_addr = 8'h0D; #1;
        chk("R1 ipv6 base", {16'h0, word_addr}, 32'h0C00);

        // Directed header contents
        write_mem(12'h808, 32'h4500_05DC);
        write_mem(12'h809, 32'h1C46_4000 | 32'h0000_1FFF);
        write_mem(12'h80A, 32'h4006_B1E6);
        write_mem(12'hC00, 32'h6AB1_2345);
        write_mem(12'hC01, 32'h0400_113F);
        for (int a = 0; a < 24; a++) read_check(a);
        read_check(255);

        // R6: base load in the same cycle as a read
        @(negedge clk);
        alias_addr = 8'h00; base_we = 1'b1; base_sel = 1'b0; base_wdata = 16'h0100;
        #1;
        chk("R6 old base before edge", {16'h0, word_addr}, 32'h0808);
        @(posedge clk); #1;
        base_we = 1'b0; m_b4 = 16'h0100;
        chk("R6 new base after edge", {16'h0, word_addr}, 32'h0100);
        fill_header(1'b0);
        for (int a = 0; a < 13; a++) read_check(a);

        // R7: memory write in the same cycle as a read of that word
        @(negedge clk);
        alias_addr = 8'h04; mem_we = 1'b1; mem_waddr = 12'h100; mem_wdata = 32'hDEAD_BEEF;
        #1;
        chk("R7 old word before edge", field_data, exp_field(4, model_mem[12'h100]));
        @(posedge clk); #1;
        mem_we = 1'b0; model_mem[12'h100] = 32'hDEAD_BEEF;
        chk("R7 new word after edge", field_data, 32'h0000_BEEF);

        // R6 on the IPv6 base
        write_base(1'b1, 16'h0FFE);
        fill_header(1'b1);
        read_check(16'h12);
        read_check(16'h0D);

        // Random mix
        for (int n = 0; n < 400; n++) begin
            int r;
            r = int'($urandom_range(0, 99));
            if (r < 8) begin
                write_mem(12'($urandom_range(0, 1) ? m_b6 + 16'($urandom_range(0, 1))
                                                   : m_b4 + 16'($urandom_range(0, 2))), $urandom);
            end else if (r < 12) begin
                logic sel;
                sel = 1'($urandom_range(0, 1));
                write_base(sel, 16'($urandom_range(0, 4093)));
                fill_header(sel);
            end else begin
                read_check(int'($urandom_range(0, 40)));
            end
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule